// File: doc/BRIEF.md
# Threshold Offset Loader

This block holds the two threshold offsets that a FIFO's flag logic uses: the almost-empty offset and the almost-full offset. It can fill them in one of two ways. In the serial method, bits arrive one per clock on a single input pin. In the parallel method, whole words are written from a data bus. Either way, both registers can be read back over a registered readback port.

The serial input pin has a second job. While master reset is active, it is sampled as a strap. That strap fixes which loading method the block accepts until the next master reset, and it also picks the default value the offsets take. Partial reset restarts the load and readback sequences. It leaves the offsets and the chosen method untouched.

Top module: `ofs_loader`

## Requirements
- R1: On a clock edge with `mrst_n` low, the strap pin `si_strap` is captured. Low selects the parallel method and high selects the serial method. Both offsets become 0x07F for the parallel method or 0x3FF for the serial method, `rd_data` becomes 0, and both sequences restart at the almost-empty offset.
- R2: In the serial method, each edge with `ld_n` low and `wr_req` high stores `si_strap` into one bit, least significant bit first. Bits 0 to OFS_W-1 of the almost-empty offset are filled first, then the same bits of the almost-full offset. After 2*OFS_W bits the sequence wraps to bit 0 of the almost-empty offset.
- R3: In the parallel method, each edge with `ld_n` low and `wr_req` high writes `wdata` into one offset. Writes alternate between the two, starting with the almost-empty offset.
- R4: The input of the method that was not selected has no effect. `wdata` is ignored in the serial method, and `si_strap` is ignored by parallel writes.
- R5: In either method, an edge with `ld_n` low and `rd_req` high loads `rd_data` with one offset. Reads alternate starting with the almost-empty offset. At all other times `rd_data` holds its value.
- R6: An edge with `prst_n` low and `mrst_n` high keeps both offsets and the selected method. It restarts both sequences at the almost-empty offset, resets the serial bit position to 0, and clears `rd_data`.
- R7: While `ld_n` is high, `wr_req` and `rd_req` change neither the offsets nor `rd_data`.
- R8: Master reset takes priority over partial reset, and partial reset takes priority over any load or readback on the same edge.
- R9: When a write and a read happen on the same edge, the read returns the offset value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, active low, sampled on the clock |
| prst_n | input | 1 | Partial reset, active low, sampled on the clock |
| ld_n | input | 1 | Offset access enable, active low |
| wr_req | input | 1 | Write or shift request while `ld_n` is low |
| rd_req | input | 1 | Readback request while `ld_n` is low |
| si_strap | input | 1 | Method strap during master reset; serial data bit afterwards |
| wdata | input | OFS_W | Parallel write data |
| ae_ofs | output | OFS_W | Almost-empty offset |
| af_ofs | output | OFS_W | Almost-full offset |
| rd_data | output | OFS_W | Registered readback value |

## Verification
The hardest state to reach is a serial load that is stopped partway. Examples are a partial reset in the middle of the almost-empty field, and a bit stream that runs past 2*OFS_W bits so the position wraps. Directed phases set up each of these. One shifts a full 24-bit pattern. One cuts a second stream short with a partial reset. One then keeps shifting across the wrap point.

A further phase drives random access, write, read, strap and reset traffic. Each method is selected in turn, so same-edge read/write pairs and reset overlaps occur in both methods.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
   typedef enum logic {
      SEL_AE = 1'b0,
      SEL_AF = 1'b1
   } ofs_sel_e;

   function automatic ofs_sel_e sel_next(input ofs_sel_e s);
      return (s == SEL_AE) ? SEL_AF : SEL_AE;
   endfunction
endpackage

// File: rtl/ofs_mode_ctrl.sv
module ofs_mode_ctrl (
   input  logic clk,
   input  logic mrst_n,
   input  logic strap,
   output logic ser_mode
);
   logic ser_mode_q;

   always_ff @(posedge clk) begin
      if (!mrst_n) ser_mode_q <= strap;
   end

   assign ser_mode = ser_mode_q;
endmodule

// File: rtl/ofs_seq_ctrl.sv
module ofs_seq_ctrl
   import ofs_pkg::*;
#(
   parameter int OFS_W = 12,
   localparam int SC_W  = $clog2(2 * OFS_W),
   localparam int IDX_W = (OFS_W > 1) ? $clog2(OFS_W) : 1
) (
   input  logic             clk,
   input  logic             mrst_n,
   input  logic             prst_n,
   input  logic             par_we,
   input  logic             ser_we,
   input  logic             rd_en,
   output ofs_sel_e         wsel,
   output ofs_sel_e         rsel,
   output ofs_sel_e         ssel,
   output logic [IDX_W-1:0] sbit
);
   localparam logic [SC_W-1:0] W_C    = SC_W'(OFS_W);
   localparam logic [SC_W-1:0] LAST_C = SC_W'(2 * OFS_W - 1);

   ofs_sel_e        wsel_q, rsel_q;
   logic [SC_W-1:0] scnt_q;

   always_ff @(posedge clk) begin
      if (!mrst_n || !prst_n) begin
         wsel_q <= SEL_AE;
         rsel_q <= SEL_AE;
         scnt_q <= '0;
      end else begin
         if (par_we) wsel_q <= sel_next(wsel_q);
         if (rd_en)  rsel_q <= sel_next(rsel_q);
         if (ser_we) scnt_q <= (scnt_q == LAST_C) ? '0 : scnt_q + 1'b1;
      end
   end

   logic            s_hi;
   logic [SC_W-1:0] s_off;

   always_comb begin
      s_hi  = (scnt_q >= W_C);
      s_off = s_hi ? (scnt_q - W_C) : scnt_q;
   end

   assign wsel = wsel_q;
   assign rsel = rsel_q;
   assign ssel = s_hi ? SEL_AF : SEL_AE;
   assign sbit = s_off[IDX_W-1:0];
endmodule

// File: rtl/ofs_readback.sv
module ofs_readback
   import ofs_pkg::*;
#(
   parameter int OFS_W = 12
) (
   input  logic             clk,
   input  logic             mrst_n,
   input  logic             prst_n,
   input  logic             rd_en,
   input  ofs_sel_e         rsel,
   input  logic [OFS_W-1:0] ae_val,
   input  logic [OFS_W-1:0] af_val,
   output logic [OFS_W-1:0] rd_data
);
   logic [OFS_W-1:0] rd_q;

   always_ff @(posedge clk) begin
      if (!mrst_n || !prst_n) rd_q <= '0;
      else if (rd_en)         rd_q <= (rsel == SEL_AF) ? af_val : ae_val;
   end

   assign rd_data = rd_q;
endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
   import ofs_pkg::*;
#(
   parameter int OFS_W   = 12,
   parameter int DEF_PAR = 'h07F,
   parameter int DEF_SER = 'h3FF,
   localparam int IDX_W  = (OFS_W > 1) ? $clog2(OFS_W) : 1
) (
   input  logic             clk,
   input  logic             mrst_n,
   input  logic             prst_n,
   input  logic             ld_n,
   input  logic             wr_req,
   input  logic             rd_req,
   input  logic             si_strap,
   input  logic [OFS_W-1:0] wdata,
   output logic [OFS_W-1:0] ae_ofs,
   output logic [OFS_W-1:0] af_ofs,
   output logic [OFS_W-1:0] rd_data
);
   if (OFS_W < 2 || OFS_W > 30) begin : g_bad_width
      $error("ofs_loader: OFS_W out of range");
   end
   if (DEF_PAR < 0 || DEF_PAR >= (1 << OFS_W)) begin : g_bad_dpar
      $error("ofs_loader: DEF_PAR does not fit OFS_W");
   end
   if (DEF_SER < 0 || DEF_SER >= (1 << OFS_W)) begin : g_bad_dser
      $error("ofs_loader: DEF_SER does not fit OFS_W");
   end

   localparam logic [OFS_W-1:0] DPAR_C = OFS_W'(DEF_PAR);
   localparam logic [OFS_W-1:0] DSER_C = OFS_W'(DEF_SER);

   logic             ser_mode_q;
   logic             acc, par_we, ser_we, rd_en;
   ofs_sel_e         wsel, rsel, ssel;
   logic [IDX_W-1:0] sbit;
   logic [OFS_W-1:0] ofs_q [2];

   ofs_mode_ctrl u_mode (
      .clk      (clk),
      .mrst_n   (mrst_n),
      .strap    (si_strap),
      .ser_mode (ser_mode_q)
   );

   assign acc    = mrst_n && prst_n && !ld_n;
   assign par_we = acc && wr_req && !ser_mode_q;
   assign ser_we = acc && wr_req &&  ser_mode_q;
   assign rd_en  = acc && rd_req;

   ofs_seq_ctrl #(.OFS_W(OFS_W)) u_seq (
      .clk    (clk),
      .mrst_n (mrst_n),
      .prst_n (prst_n),
      .par_we (par_we),
      .ser_we (ser_we),
      .rd_en  (rd_en),
      .wsel   (wsel),
      .rsel   (rsel),
      .ssel   (ssel),
      .sbit   (sbit)
   );

   for (genvar g = 0; g < 2; g++) begin : g_ofs
      logic par_hit, ser_hit;
      logic [OFS_W-1:0] ser_nxt;

      assign par_hit = par_we && (wsel == ofs_sel_e'(g));
      assign ser_hit = ser_we && (ssel == ofs_sel_e'(g));

      always_comb begin
         ser_nxt = ofs_q[g];
         ser_nxt[sbit] = si_strap;
      end

      always_ff @(posedge clk) begin
         if (!mrst_n)      ofs_q[g] <= si_strap ? DSER_C : DPAR_C;
         else if (par_hit) ofs_q[g] <= wdata;
         else if (ser_hit) ofs_q[g] <= ser_nxt;
      end
   end

   assign ae_ofs = ofs_q[0];
   assign af_ofs = ofs_q[1];

   ofs_readback #(.OFS_W(OFS_W)) u_rb (
      .clk     (clk),
      .mrst_n  (mrst_n),
      .prst_n  (prst_n),
      .rd_en   (rd_en),
      .rsel    (rsel),
      .ae_val  (ofs_q[0]),
      .af_val  (ofs_q[1]),
      .rd_data (rd_data)
   );
endmodule

// File: rtl/ofs_loader_chk.sv
module ofs_loader_chk #(
   parameter int OFS_W   = 12,
   parameter int DEF_PAR = 'h07F,
   parameter int DEF_SER = 'h3FF
) (
   input logic             clk,
   input logic             mrst_n,
   input logic             prst_n,
   input logic             ld_n,
   input logic             wr_req,
   input logic             ser_mode,
   input logic [OFS_W-1:0] ae_ofs,
   input logic [OFS_W-1:0] af_ofs,
   input logic [OFS_W-1:0] rd_data
);
   logic mrst_seen_q;
   always_ff @(posedge clk) mrst_seen_q <= !mrst_n;

   AST_MRST_DEFAULT: assert property (@(posedge clk) disable iff (!mrst_n)
      mrst_seen_q |-> (ae_ofs == af_ofs) &&
                      (ae_ofs == OFS_W'(DEF_PAR) || ae_ofs == OFS_W'(DEF_SER))); // R1

   AST_SER_ONE_BIT: assert property (@(posedge clk) disable iff (!mrst_n)
      (prst_n && !ld_n && wr_req && ser_mode) |=>
         ($countones({ae_ofs, af_ofs} ^ $past({ae_ofs, af_ofs})) <= 1)); // R2

   AST_PAR_ONE_REG: assert property (@(posedge clk) disable iff (!mrst_n)
      (prst_n && !ld_n && wr_req && !ser_mode) |=>
         ($stable(ae_ofs) || $stable(af_ofs))); // R3

   AST_PRST_KEEP: assert property (@(posedge clk) disable iff (!mrst_n)
      !prst_n |=> ($stable(ae_ofs) && $stable(af_ofs) && rd_data == '0)); // R6

   AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (!mrst_n)
      (prst_n && ld_n) |=> ($stable(ae_ofs) && $stable(af_ofs) && $stable(rd_data))); // R7
endmodule

bind ofs_loader ofs_loader_chk #(
   .OFS_W   (OFS_W),
   .DEF_PAR (DEF_PAR),
   .DEF_SER (DEF_SER)
) u_chk (
   .clk      (clk),
   .mrst_n   (mrst_n),
   .prst_n   (prst_n),
   .ld_n     (ld_n),
   .wr_req   (wr_req),
   .ser_mode (ser_mode_q),
   .ae_ofs   (ae_ofs),
   .af_ofs   (af_ofs),
   .rd_data  (rd_data)
);

// File: tb/test_ofs_loader.sv
module test_ofs_loader;
   localparam int W = 12;

   logic         clk = 1'b0;
   logic         mrst_n = 1'b0, prst_n = 1'b1, ld_n = 1'b1;
   logic         wr_req = 1'b0, rd_req = 1'b0, si_strap = 1'b0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] ae_ofs, af_ofs, rd_data;

   int checks = 0;
   int errors = 0;

   // behavioural reference state
   bit           m_ser;
   logic [W-1:0] m_ae, m_af, m_rd;
   int           m_wp, m_rp, m_sc;
   bit           m_valid = 0;

   always #5 clk = ~clk;

   ofs_loader #(.OFS_W(W)) i_ofs_loader (
      .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ld_n(ld_n),
      .wr_req(wr_req), .rd_req(rd_req), .si_strap(si_strap),
      .wdata(wdata), .ae_ofs(ae_ofs), .af_ofs(af_ofs), .rd_data(rd_data)
   );

   task automatic check(input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic model_edge();
      logic [W-1:0] ae0 = m_ae, af0 = m_af;
      if (!mrst_n) begin
         m_ser = si_strap;
         m_ae  = si_strap ? 12'h3FF : 12'h07F;
         m_af  = m_ae;
         m_rd  = '0; m_wp = 0; m_rp = 0; m_sc = 0;
         m_valid = 1;
      end else if (!prst_n) begin
         m_rd = '0; m_wp = 0; m_rp = 0; m_sc = 0;
      end else if (!ld_n) begin
         if (rd_req) begin
            m_rd = (m_rp == 1) ? af0 : ae0;
            m_rp ^= 1;
         end
         if (wr_req) begin
            if (m_ser) begin
               if (m_sc < W) m_ae[m_sc]     = si_strap;
               else          m_af[m_sc - W] = si_strap;
               m_sc = (m_sc + 1) % (2 * W);
            end else begin
               if (m_wp == 0) m_ae = wdata; else m_af = wdata;
               m_wp ^= 1;
            end
         end
      end
   endtask

   task automatic step(input string req, input bit mr, input bit pr, input bit ld,
                       input bit wr, input bit rd, input bit si, input logic [W-1:0] wd);
      mrst_n = mr; prst_n = pr; ld_n = ld; wr_req = wr; rd_req = rd;
      si_strap = si; wdata = wd;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      if (m_valid) begin
         check(req, "ae_ofs",  ae_ofs,  m_ae);
         check(req, "af_ofs",  af_ofs,  m_af);
         check(req, "rd_data", rd_data, m_rd);
      end
   endtask

   initial begin : watchdog
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      logic [2*W-1:0] pat;
      // R1: parallel method strap and defaults
      step("R1", 0, 1, 1, 0, 0, 0, 12'hFFF);
      check("R1", "ae default par", ae_ofs, 12'h07F);
      step("R1", 1, 1, 1, 0, 0, 1, 12'h000);
      // R3 / R4: parallel writes with si toggling
      step("R3", 1, 1, 0, 1, 0, 1, 12'hABC);
      step("R4", 1, 1, 0, 1, 0, 0, 12'h123);
      check("R3", "af written", af_ofs, 12'h123);
      // R5 readback
      step("R5", 1, 1, 0, 0, 1, 0, 12'h000);
      check("R5", "rd ae", rd_data, 12'hABC);
      step("R5", 1, 1, 0, 0, 1, 0, 12'h000);
      step("R5", 1, 1, 1, 0, 0, 0, 12'h000);
      // R7: requests with ld_n high
      step("R7", 1, 1, 1, 1, 1, 1, 12'h555);
      step("R7", 1, 1, 1, 1, 0, 0, 12'h666);
      // write one then partial reset: R6
      step("R3", 1, 1, 0, 1, 1, 0, 12'h777);
      step("R6", 1, 0, 0, 1, 1, 1, 12'h888);
      // R9: same-edge read and write, both restart at AE
      step("R9", 1, 1, 0, 1, 1, 0, 12'h999);
      step("R9", 1, 1, 0, 1, 1, 0, 12'hAAA);
      // R8: both resets together, strap high -> serial method
      step("R8", 0, 0, 0, 1, 1, 1, 12'hBBB);
      check("R1", "ae default ser", ae_ofs, 12'h3FF);
      // R2 / R4: full 24-bit serial pattern with garbage wdata
      pat = 24'h5A3_C96;
      for (int i = 0; i < 2 * W; i++) step("R2", 1, 1, 0, 1, 0, pat[i], 12'hFFF);
      check("R2", "ae serial", ae_ofs, 12'hC96);
      check("R2", "af serial", af_ofs, 12'h5A3);
      step("R5", 1, 1, 0, 0, 1, 0, 12'h000);
      step("R5", 1, 1, 0, 0, 1, 0, 12'h000);
      // partial load then partial reset restarts at bit 0
      for (int i = 0; i < 7; i++) step("R2", 1, 1, 0, 1, 0, 1'b0, 12'h000);
      step("R6", 1, 0, 0, 1, 0, 1, 12'h000);
      for (int i = 0; i < 30; i++) step("R2", 1, 1, 0, 1, i[0], i[1] ^ i[3], 12'h000);
      // random traffic in both methods
      for (int i = 0; i < 1500; i++) begin
         bit mr = ($urandom_range(0, 60) != 0);
         bit pr = ($urandom_range(0, 25) != 0);
         step("R8", mr, pr, $urandom_range(0, 3) == 0, $urandom_range(0, 1),
              $urandom_range(0, 1), $urandom_range(0, 1), W'($urandom));
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule